// File: doc/BRIEF.md
# Receive-Path Companded Sample Expander

This block sits behind the deserializer of a serial port and turns each received 8-bit G.711 code into a linear sample. A 2-bit companding mode selects mu-law expansion, A-law expansion, or raw pass-through. An expanded sample is first placed at the top of a 16-bit container. That container is then put into a 32-bit receive word in one of three ways: in the low half with the high half cleared, in the low half with the high half filled from the container's sign, or in the high half with the low half cleared. The fourth justification code is reserved. It raises an error flag and yields a zero word.

Elements arrive on a valid/ready input and leave as 32-bit words on a valid/ready output. The input element may be wider than 8 bits, but only its low 8 bits are ever used. A single output register holds the result. A two-state controller tracks whether that register holds a word. **ST_EMPTY** means the register holds nothing. In that state the input is always ready, and an accepted element moves the controller to **ST_HOLD** (transition *load*). **ST_HOLD** means a word is presented. If the word is taken and no new element arrives, the controller returns to ST_EMPTY (transition *drain*). If the word is taken in the same cycle that a new element is accepted, it stays in ST_HOLD with the new word (transition *reload*). If the word is not taken, it stays in ST_HOLD with the input not ready (transition *stall*).

Top module: `rx_compand_expander`

## Requirements
- R1: Only bits 7:0 of `elem_data` affect the result; every higher bit of the element is ignored.
- R2: Mode 2'b10 gives mu-law expansion. The code is complemented. Bit 7 set after complementing means negative. With segment s = bits 6:4 and mantissa m = bits 3:0, the magnitude is ((2m+33)<<s)−33. The signed 14-bit result sits in container bits 15:2, and bits 1:0 are zero.
- R3: Mode 2'b11 gives A-law expansion. The code is XORed with 8'h55. Bit 7 set after XOR means positive. The magnitude is 2m+1 for segment 0 and (2m+33)<<(s−1) otherwise. The signed 13-bit result sits in container bits 15:3, and bits 2:0 are zero.
- R4: Justification 2'b00 puts the container in word bits 15:0, with bits 31:16 zero.
- R5: Justification 2'b01 puts the container in bits 15:0, with bits 31:16 equal to container bit 15.
- R6: Justification 2'b10 puts the container in bits 31:16, with bits 15:0 zero.
- R7: Justification 2'b11 gives `word_err`=1 and a zero word, in every mode. For every other justification `word_err`=0.
- R8: Modes 2'b00 and 2'b01 pass the code without companding. Justification 00 gives {24'b0,code}. Justification 01 gives the code sign-extended from its bit 7. Justification 10 gives {code,24'b0}.
- R9: An element accepted at a clock edge shows as `word_valid`=1 with its result right after that edge. The mode and justification in use are the ones present at acceptance.
- R10: While `word_valid`=1 and `word_ready`=0, the word and its error flag stay unchanged and `elem_ready`=0. With no word held, `elem_ready`=1.
- R11: After reset: `word_valid`=0, `elem_ready`=1, the word is zero, and `word_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Companding mode (00/01 raw, 10 mu-law, 11 A-law) |
| cfg_just | input | 2 | Word justification (00 low/zero, 01 low/sign, 10 high, 11 reserved) |
| elem_valid | input | 1 | Received element present |
| elem_ready | output | 1 | Element can be accepted |
| elem_data | input | ELEM_W | Received element; only bits 7:0 are used |
| word_valid | output | 1 | Output word present |
| word_ready | input | 1 | Output word taken |
| word_data | output | 32 | Justified linear word |
| word_err | output | 1 | Reserved justification was selected |

## Verification
The hardest case to reach is the *reload* transition under back-pressure. A word is held with `word_ready` low while a different element waits at the input. Then the consumer releases, and the old word must leave at the same edge that the new element is accepted. The stimulus first stalls the output for several cycles with a second element already presented. It checks that the word is unchanged and the input not ready. Then it raises `word_ready` and checks that the second result appears at the next edge. The full sweep covers all 256 codes under every mode and justification. It places a changing pattern in the unused high element bits.

// File: rtl/rx_compand_pkg.sv
package rx_compand_pkg;

    localparam int CODE_W = 8;
    localparam int CONT_W = 16;
    localparam int WORD_W = 2 * CONT_W;
    localparam int MU_W   = 14;
    localparam int AL_W   = 13;

    typedef enum logic [1:0] {
        CM_RAW_A = 2'b00,
        CM_RAW_B = 2'b01,
        CM_MULAW = 2'b10,
        CM_ALAW  = 2'b11
    } cmode_e;

    typedef enum logic [1:0] {
        JU_LOW_ZERO = 2'b00,
        JU_LOW_SIGN = 2'b01,
        JU_HIGH     = 2'b10,
        JU_RSVD     = 2'b11
    } just_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } hold_state_e;

endpackage

// File: rtl/mulaw_expand.sv
module mulaw_expand
    import rx_compand_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [CONT_W-1:0] container
);
    localparam int PAD_W = CONT_W - MU_W;
    localparam logic [MU_W-1:0] BIAS = MU_W'(33);

    logic [CODE_W-1:0] inv;
    logic [2:0]        seg;
    logic [3:0]        mant;
    logic [MU_W-1:0]   base;
    logic [MU_W-1:0]   mag;
    logic [MU_W-1:0]   lin;

    always_comb begin
        inv  = ~code;
        seg  = inv[6:4];
        mant = inv[3:0];
        base = MU_W'({mant, 1'b0}) + BIAS;
        mag  = (base << seg) - BIAS;
        lin  = inv[7] ? (~mag + MU_W'(1)) : mag;
        container = {lin, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/alaw_expand.sv
module alaw_expand
    import rx_compand_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [CONT_W-1:0] container
);
    localparam int PAD_W = CONT_W - AL_W;
    localparam logic [CODE_W-1:0] TOGGLE = 8'h55;

    logic [CODE_W-1:0] dec;
    logic [2:0]        seg;
    logic [AL_W-1:0]   step;
    logic [AL_W-1:0]   mag;
    logic [AL_W-1:0]   lin;

    always_comb begin
        dec  = code ^ TOGGLE;
        seg  = dec[6:4];
        step = AL_W'({dec[3:0], 1'b1});
        if (seg == 3'd0)
            mag = step;
        else
            mag = (step + AL_W'(32)) << (seg - 3'd1);
        lin = dec[7] ? mag : (~mag + AL_W'(1));
        container = {lin, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/word_justify.sv
module word_justify
    import rx_compand_pkg::*;
(
    input  logic              raw,
    input  logic [CODE_W-1:0] code,
    input  logic [CONT_W-1:0] container,
    input  logic [1:0]        just,
    output logic [WORD_W-1:0] word,
    output logic              err
);
    localparam int RAW_PAD = WORD_W - CODE_W;

    always_comb begin
        word = '0;
        err  = 1'b0;
        unique case (just_e'(just))
            JU_LOW_ZERO: word = raw ? {{RAW_PAD{1'b0}}, code}
                                    : {{CONT_W{1'b0}}, container};
            JU_LOW_SIGN: word = raw ? {{RAW_PAD{code[CODE_W-1]}}, code}
                                    : {{CONT_W{container[CONT_W-1]}}, container};
            JU_HIGH:     word = raw ? {code, {RAW_PAD{1'b0}}}
                                    : {container, {CONT_W{1'b0}}};
            JU_RSVD: begin
                word = '0;
                err  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/rx_compand_expander.sv
module rx_compand_expander
    import rx_compand_pkg::*;
#(
    parameter int ELEM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_just,
    input  logic              elem_valid,
    output logic              elem_ready,
    input  logic [ELEM_W-1:0] elem_data,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [31:0]       word_data,
    output logic              word_err
);
    logic [CODE_W-1:0] code;
    logic [CONT_W-1:0] mu_cont, al_cont, sel_cont;
    logic [WORD_W-1:0] next_word;
    logic              next_err, is_raw, accept;
    logic [1:0]        held_mode, held_just;
    hold_state_e       state, state_nx;

    assign code = elem_data[CODE_W-1:0];

    mulaw_expand u_mu (.code(code), .container(mu_cont));
    alaw_expand  u_al (.code(code), .container(al_cont));

    always_comb begin
        is_raw   = 1'b0;
        sel_cont = '0;
        unique case (cmode_e'(cfg_mode))
            CM_RAW_A, CM_RAW_B: is_raw = 1'b1;
            CM_MULAW:           sel_cont = mu_cont;
            CM_ALAW:            sel_cont = al_cont;
        endcase
    end

    word_justify u_just (
        .raw(is_raw), .code(code), .container(sel_cont),
        .just(cfg_just), .word(next_word), .err(next_err)
    );

    // outputs of the controller
    always_comb begin
        elem_ready = 1'b1;
        word_valid = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                elem_ready = 1'b1;
                word_valid = 1'b0;
            end
            ST_HOLD: begin
                elem_ready = word_ready;
                word_valid = 1'b1;
            end
        endcase
    end

    assign accept = elem_valid && elem_ready;

    // next-state: load, drain, reload, stall
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (accept) state_nx = ST_HOLD;
            ST_HOLD:  if (word_ready && !accept) state_nx = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_data <= '0;
            word_err  <= 1'b0;
            held_mode <= 2'b00;
            held_just <= 2'b00;
        end else if (accept) begin
            word_data <= next_word;
            word_err  <= next_err;
            held_mode <= cfg_mode;
            held_just <= cfg_just;
        end
    end
endmodule

// File: rtl/rx_compand_expander_chk.sv
module rx_compand_expander_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        elem_valid,
    input logic        elem_ready,
    input logic        word_valid,
    input logic        word_ready,
    input logic [31:0] word_data,
    input logic        word_err,
    input logic [1:0]  held_mode,
    input logic [1:0]  held_just
);
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !word_ready |=> word_valid && $stable(word_data) && $stable(word_err));

    // R10
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> elem_ready);

    // R9
    accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid && elem_ready |=> word_valid);

    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && held_just == 2'b11 |-> word_err && word_data == 32'h0);

    // R2
    mu_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && held_mode == 2'b10 && held_just == 2'b00 |->
            word_data[1:0] == 2'b00 && word_data[31:16] == 16'h0);

    // R3
    al_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && held_mode == 2'b11 && held_just == 2'b10 |->
            word_data[18:0] == 19'h0);
endmodule

bind rx_compand_expander rx_compand_expander_chk u_chk (
    .clk(clk), .rst_n(rst_n), .elem_valid(elem_valid), .elem_ready(elem_ready),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .word_err(word_err), .held_mode(held_mode), .held_just(held_just)
);

// File: tb/rx_compand_expander_test.sv
module rx_compand_expander_test;
    localparam int EW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = 2'b00, cfg_just = 2'b00;
    logic          elem_valid = 1'b0, word_ready = 1'b1;
    logic [EW-1:0] elem_data = '0;
    logic          elem_ready, word_valid, word_err;
    logic [31:0]   word_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rx_compand_expander #(.ELEM_W(EW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_just(cfg_just),
        .elem_valid(elem_valid), .elem_ready(elem_ready), .elem_data(elem_data),
        .word_valid(word_valid), .word_ready(word_ready),
        .word_data(word_data), .word_err(word_err)
    );

    task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic int mu_lin(input logic [7:0] c);
        logic [7:0] u = ~c;
        int m = ((2 * int'(u[3:0]) + 33) * (1 << int'(u[6:4]))) - 33;
        return u[7] ? -m : m;
    endfunction

    function automatic int al_lin(input logic [7:0] c);
        logic [7:0] a = c ^ 8'h55;
        int s = int'(a[6:4]);
        int m = (s == 0) ? 2 * int'(a[3:0]) + 1
                         : (2 * int'(a[3:0]) + 33) * (1 << (s - 1));
        return a[7] ? m : -m;
    endfunction

    function automatic logic [32:0] expect_word(input logic [1:0] md, input logic [1:0] js,
                                                input logic [7:0] c);
        logic [15:0] cont;
        int sc;
        if (js == 2'b11) return {1'b1, 32'h0};
        if (md[1] == 1'b0) begin
            sc = (js == 2'b01) ? int'($signed(c)) : int'(c);
            if (js == 2'b10) return {1'b0, c, 24'h0};
            return {1'b0, 32'(sc)};
        end
        cont = (md == 2'b10) ? 16'(mu_lin(c) * 4) : 16'(al_lin(c) * 8);
        if (js == 2'b10) return {1'b0, cont, 16'h0};
        if (js == 2'b01) return {1'b0, 32'(int'($signed(cont)))};
        return {1'b0, 16'h0, cont};
    endfunction

    function automatic string tag_of(input logic [1:0] md, input logic [1:0] js);
        if (js == 2'b11) return "R7";
        if (md == 2'b10) return (js == 2'b00) ? "R2/R4" : (js == 2'b01) ? "R2/R5" : "R2/R6";
        if (md == 2'b11) return (js == 2'b00) ? "R3/R4" : (js == 2'b01) ? "R3/R5" : "R3/R6";
        return "R8/R1";
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
                finish_up();
            end
        end
    end

    initial begin
        logic [32:0] e;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 valid", {32'h0, word_valid}, 33'h0);
        chk("R11 ready", {32'h0, elem_ready}, 33'h1);
        chk("R11 word", {word_err, word_data}, 33'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // full sweep: R1..R9
        for (int md = 0; md < 4; md++) begin
            for (int js = 0; js < 4; js++) begin
                for (int c = 0; c < 256; c++) begin
                    cfg_mode   = 2'(md);
                    cfg_just   = 2'(js);
                    elem_data  = {8'(c * 37 + md + 1), 8'(c)};
                    elem_valid = 1'b1;
                    @(negedge clk);
                    elem_valid = 1'b0;
                    cfg_mode   = ~2'(md);
                    cfg_just   = ~2'(js);
                    chk("R9 valid", {32'h0, word_valid}, 33'h1);
                    chk(tag_of(2'(md), 2'(js)), {word_err, word_data},
                        expect_word(2'(md), 2'(js), 8'(c)));
                    @(negedge clk);
                end
            end
        end

        // R10 back-pressure then reload
        word_ready = 1'b0;
        cfg_mode = 2'b10; cfg_just = 2'b01; elem_data = 16'h0012; elem_valid = 1'b1;
        @(negedge clk);
        e = expect_word(2'b10, 2'b01, 8'h12);
        elem_data = 16'hFF9A; cfg_mode = 2'b11; cfg_just = 2'b00;
        for (int k = 0; k < 4; k++) begin
            chk("R10 held", {word_err, word_data}, e);
            chk("R10 not ready", {32'h0, elem_ready}, 33'h0);
            @(negedge clk);
        end
        word_ready = 1'b1;
        @(negedge clk);
        elem_valid = 1'b0;
        chk("R10 reload", {word_err, word_data}, expect_word(2'b11, 2'b00, 8'h9A));
        chk("R10 reload valid", {32'h0, word_valid}, 33'h1);
        @(negedge clk);
        chk("R10 drained", {32'h0, word_valid}, 33'h0);
        chk("R10 empty ready", {32'h0, elem_ready}, 33'h1);

        // R7 reserved under back-pressure keeps error flag
        word_ready = 1'b0;
        cfg_mode = 2'b00; cfg_just = 2'b11; elem_data = 16'h00FF; elem_valid = 1'b1;
        @(negedge clk);
        elem_valid = 1'b0;
        @(negedge clk);
        chk("R7 held err", {word_err, word_data}, {1'b1, 32'h0});
        word_ready = 1'b1;
        @(negedge clk);
        finish_up();
    end
endmodule